// File: doc/BRIEF.md
# Power-Good Reset Pulse Sequencer

This block turns a power-good input into a bounded active-low reset for a bus agent. Power-good first passes through a two-flop synchronizer. A rising edge counts only when the synchronized level stays high for a minimum number of reference clocks. A qualified rise starts a hold interval. Its length is programmed in clock cycles, and the block raises it to the minimum reset time or cuts it to the maximum. Reset is released synchronously when the interval ends.

Whenever power-good goes low, reset is asserted at once without waiting for a clock. The synchronizer, the qualifier and the sequencer are cleared at that moment, so the next sequence starts only from a fresh qualified rise. The bus output drivers are held disabled while reset is active. On the clock edge that releases reset, a configuration word is sampled from shared bus pins. A programmed hold longer than the maximum sets a sticky timeout flag.

The time bounds come from parameters: the clock frequency in kHz, the minimum and maximum reset time, and the minimum power-good width, all in microseconds. The block converts these to cycle counts, and the counter widths follow from them.

Top module: `pwrgood_rst_seq`

## Requirements
- R1: While rst_ni is low, rst_no is 0, bus_off_o is 1, cfg_word_o is all zeros and timeout_err_o is 0.
- R2: A power-good high period shorter than PG_CYC synchronized cycles never releases reset, however long the block then waits.
- R3: After power-good rises (driven between clock edges) and stays high, rst_no rises on exactly the (3 + PG_CYC + L)-th rising clock edge. L is the hold interval: hold_cyc_i clamped to the range [MIN_CYC, MAX_CYC].
- R4: A hold_cyc_i value below MIN_CYC gives a reset pulse of MIN_CYC cycles, so L = MIN_CYC.
- R5: A hold_cyc_i value above MAX_CYC releases reset after MAX_CYC cycles and sets timeout_err_o on the release edge. A value inside the range leaves the flag at 0. Once set, the flag stays set, including across power-good loss, until rst_ni is asserted.
- R6: When pwr_good_i goes low, rst_no goes low with no clock edge and stays low. This also applies during the hold interval. The next release then follows the full R3 timing, counted from the next rise.
- R7: bus_off_o is 1 whenever rst_no is 0. After a release it stays 1 for one more clock edge and drops to 0 on the edge after the release edge.
- R8: cfg_word_o takes the value of cfg_pins_i at the clock edge on which rst_no rises. It holds that value after the release, through power-good loss, until the next release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous block reset |
| pwr_good_i | input | 1 | Raw power-good level, asynchronous |
| hold_cyc_i | input | CNT_W | Programmed reset hold length in cycles |
| cfg_pins_i | input | CFG_W | Shared bus pins sampled as configuration |
| rst_no | output | 1 | Active-low reset to the bus agent |
| bus_off_o | output | 1 | Forces the bus output drivers inactive |
| cfg_word_o | output | CFG_W | Configuration captured at reset release |
| timeout_err_o | output | 1 | Sticky flag: programmed hold exceeded maximum |

## Verification
The bound checker watches, on every cycle, four things:
- that low power-good always means reset is active;
- that the bus drivers are disabled on the edge after any active-reset cycle;
- that the captured configuration and the timeout flag change only where allowed;
- that every release comes after at least the minimum low time and no later than the maximum bound plus the qualification delay.

Only the directed scenarios can show four other things: the exact release edge for in-range, short and long holds, the rejection of a short power-good pulse, the restart after a drop during the hold, and which pin value the configuration word captures.

// File: rtl/pgrs_pkg.sv
package pgrs_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'b00,
    ST_HOLD = 2'b01,
    ST_RUN  = 2'b10
  } seq_st_e;

  // Microseconds to clock cycles, rounded up, never below one.
  function automatic int unsigned us_to_cyc(input int unsigned khz, input int unsigned us);
    longint unsigned c;
    c = (longint'(khz) * longint'(us) + 64'd999) / 64'd1000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/pgrs_sync.sv
module pgrs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sr_q <= '0;
    else          sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pgrs_qual.sv
module pgrs_qual #(
  parameter int unsigned PG_CYC = 10,
  localparam int unsigned QW    = $clog2(PG_CYC + 1)
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic pg_i,
  output logic qual_o
);
  localparam logic [QW-1:0] LAST = QW'(PG_CYC - 1);

  logic [QW-1:0] cnt_q;
  logic          qual_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
    end else if (!pg_i) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
    end else if (!qual_q) begin
      if (cnt_q == LAST) qual_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign qual_o = qual_q;
endmodule

// File: rtl/pgrs_timer.sv
module pgrs_timer
  import pgrs_pkg::*;
#(
  parameter int unsigned MIN_CYC = 20,
  parameter int unsigned MAX_CYC = 200,
  parameter int unsigned CNT_W   = 9
) (
  input  logic             clk_i,
  input  logic             arst_ni,
  input  logic             pg_i,
  input  logic             qual_i,
  input  logic [CNT_W-1:0] hold_cyc_i,
  output logic             run_o,
  output logic             rel_o,
  output logic             over_o
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CYC);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_CYC);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q, lim_q, lim_d;
  logic             over_q;

  always_comb begin
    if (hold_cyc_i < MIN_V)      lim_d = MIN_V;
    else if (hold_cyc_i > MAX_V) lim_d = MAX_V;
    else                         lim_d = hold_cyc_i;
  end

  assign rel_o = (st_q == ST_HOLD) && pg_i && (cnt_q == lim_q - 1'b1);

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      st_q   <= ST_OFF;
      cnt_q  <= '0;
      lim_q  <= MIN_V;
      over_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_OFF: if (pg_i && qual_i) begin
          st_q   <= ST_HOLD;
          cnt_q  <= '0;
          lim_q  <= lim_d;
          over_q <= hold_cyc_i > MAX_V;
        end
        ST_HOLD: begin
          if (!pg_i)      st_q  <= ST_OFF;
          else if (rel_o) st_q  <= ST_RUN;
          else            cnt_q <= cnt_q + 1'b1;
        end
        ST_RUN:  if (!pg_i) st_q <= ST_OFF;
        default: st_q <= ST_OFF;
      endcase
    end
  end

  assign run_o  = (st_q == ST_RUN);
  assign over_o = over_q;
endmodule

// File: rtl/pwrgood_rst_seq.sv
module pwrgood_rst_seq #(
  parameter int unsigned CLK_KHZ    = 100000,
  parameter int unsigned MIN_RST_US = 1000,
  parameter int unsigned MAX_RST_US = 10000,
  parameter int unsigned PG_MIN_US  = 10,
  parameter int unsigned CFG_W      = 8,
  localparam int unsigned MIN_CYC   = pgrs_pkg::us_to_cyc(CLK_KHZ, MIN_RST_US),
  localparam int unsigned MAX_CYC   = pgrs_pkg::us_to_cyc(CLK_KHZ, MAX_RST_US),
  localparam int unsigned PG_CYC    = pgrs_pkg::us_to_cyc(CLK_KHZ, PG_MIN_US),
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_good_i,
  input  logic [CNT_W-1:0] hold_cyc_i,
  input  logic [CFG_W-1:0] cfg_pins_i,
  output logic             rst_no,
  output logic             bus_off_o,
  output logic [CFG_W-1:0] cfg_word_o,
  output logic             timeout_err_o
);
  // Loss of power-good clears the whole sequence without a clock.
  logic arst_n;
  assign arst_n = rst_ni & pwr_good_i;

  logic pg_s, qual, run, rel, over;

  pgrs_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .arst_ni(arst_n), .d_i(pwr_good_i), .q_o(pg_s)
  );

  pgrs_qual #(.PG_CYC(PG_CYC)) u_qual (
    .clk_i(clk_i), .arst_ni(arst_n), .pg_i(pg_s), .qual_o(qual)
  );

  pgrs_timer #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC), .CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .arst_ni(arst_n), .pg_i(pg_s), .qual_i(qual),
    .hold_cyc_i(hold_cyc_i), .run_o(run), .rel_o(rel), .over_o(over)
  );

  logic bus_off_q;
  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) bus_off_q <= 1'b1;
    else         bus_off_q <= ~run;
  end

  logic [CFG_W-1:0] cfg_q;
  logic             err_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else if (rel) begin
      cfg_q <= cfg_pins_i;
      err_q <= err_q | over;
    end
  end

  assign rst_no        = run;
  assign bus_off_o     = bus_off_q;
  assign cfg_word_o    = cfg_q;
  assign timeout_err_o = err_q;
endmodule

// File: rtl/pwrgood_rst_seq_chk.sv
module pwrgood_rst_seq_chk #(
  parameter int unsigned MIN_CYC = 20,
  parameter int unsigned MAX_CYC = 200,
  parameter int unsigned PG_CYC  = 10,
  parameter int unsigned CFG_W   = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwr_good_i,
  input logic             rst_no,
  input logic             bus_off_o,
  input logic [CFG_W-1:0] cfg_word_o,
  input logic             timeout_err_o
);
  localparam int unsigned BOUND = MAX_CYC + PG_CYC + 3;
  localparam int unsigned LW    = $clog2(BOUND + 2) + 1;
  localparam logic [LW-1:0] SAT = {LW{1'b1}};

  logic [LW-1:0] low_cnt, pg_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt    <= '0;
      pg_low_cnt <= '0;
    end else begin
      if (rst_no)             low_cnt <= '0;
      else if (low_cnt < SAT) low_cnt <= low_cnt + 1'b1;
      if (rst_no || !pwr_good_i) pg_low_cnt <= '0;
      else if (pg_low_cnt < SAT) pg_low_cnt <= pg_low_cnt + 1'b1;
    end
  end

  AST_MIN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> low_cnt >= LW'(MIN_CYC)); // R4

  AST_MAX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_no && pwr_good_i) |-> pg_low_cnt <= LW'(BOUND)); // R3

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_err_o |=> timeout_err_o); // R5

  AST_PG_LOW_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> !rst_no); // R6

  AST_BUS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no |=> bus_off_o); // R7

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_no) |-> $stable(cfg_word_o)); // R8
endmodule

bind pwrgood_rst_seq pwrgood_rst_seq_chk #(
  .MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC), .PG_CYC(PG_CYC), .CFG_W(CFG_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_good_i(pwr_good_i), .rst_no(rst_no),
  .bus_off_o(bus_off_o), .cfg_word_o(cfg_word_o), .timeout_err_o(timeout_err_o)
);

// File: tb/pwrgood_rst_seq_tb_top.sv
`timescale 1ns/1ps
module pwrgood_rst_seq_tb_top;
  // 20 kHz scaling: 1 ms = 20 cycles, 10 ms = 200 cycles, 500 us = 10 cycles
  localparam int MIN_C = 20;
  localparam int MAX_C = 200;
  localparam int PG_C  = 10;
  localparam int CW    = 9;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          pg = 0;
  logic [CW-1:0] hold = '0;
  logic [7:0]    cfg_pins = '0;
  logic          rst_out_n, bus_off, err;
  logic [7:0]    cfg_word;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwrgood_rst_seq #(.CLK_KHZ(20), .PG_MIN_US(500)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .hold_cyc_i(hold),
    .cfg_pins_i(cfg_pins), .rst_no(rst_out_n), .bus_off_o(bus_off),
    .cfg_word_o(cfg_word), .timeout_err_o(err)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clamp(input int h);
    if (h < MIN_C) return MIN_C;
    if (h > MAX_C) return MAX_C;
    return h;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Raise power-good and follow one full sequence to release.
  task automatic run_seq(input int h, input logic [7:0] c, input logic exp_err, input string req);
    int n;
    n = 3 + PG_C + clamp(h);
    @(negedge clk);
    hold = CW'(h); cfg_pins = c; pg = 1'b1;
    repeat (n - 1) @(posedge clk);
    @(negedge clk);
    chk(req, "rst_no one edge before release", rst_out_n, 0);
    chk("R7", "bus_off before release", bus_off, 1);
    @(posedge clk);
    @(negedge clk);
    chk(req, "rst_no at release edge", rst_out_n, 1);
    chk("R7", "bus_off on release edge", bus_off, 1);
    chk("R8", "cfg captured", cfg_word, c);
    chk("R5", "timeout flag after release", err, exp_err);
    cfg_pins = ~c;
    @(posedge clk);
    @(negedge clk);
    chk("R7", "bus_off one edge after release", bus_off, 0);
    chk("R8", "cfg holds after pins change", cfg_word, c);
  endtask

  task automatic drop_pg(input int cyc);
    @(negedge clk);
    pg = 1'b0;
    #1;
    chk("R6", "rst_no async on drop", rst_out_n, 0);
    chk("R7", "bus_off on drop", bus_off, 1);
    wait_cyc(cyc);
  endtask

  task automatic t_reset();
    rst_n = 0; pg = 1'b1;
    wait_cyc(3);
    chk("R1", "rst_no in reset", rst_out_n, 0);
    chk("R1", "bus_off in reset", bus_off, 1);
    chk("R1", "cfg in reset", cfg_word, 0);
    chk("R1", "err in reset", err, 0);
    pg = 1'b0;
    @(negedge clk);
    rst_n = 1;
    wait_cyc(2);
  endtask

  task automatic t_normal();
    run_seq(30, 8'hA5, 1'b0, "R3");
  endtask

  task automatic t_drop_run();
    drop_pg(3);
    chk("R8", "cfg kept across pg loss", cfg_word, 8'hA5);
    run_seq(45, 8'h3C, 1'b0, "R3");
  endtask

  task automatic t_short_hold();
    drop_pg(3);
    run_seq(5, 8'h81, 1'b0, "R4");
  endtask

  task automatic t_glitch();
    drop_pg(3);
    @(negedge clk);
    hold = CW'(30); pg = 1'b1;
    wait_cyc(PG_C - 1);
    pg = 1'b0;
    wait_cyc(2);
    pg = 1'b1; // stays high only PG_C-3 cycles
    wait_cyc(PG_C - 3);
    pg = 1'b0;
    wait_cyc(300);
    chk("R2", "short pg pulses never release", rst_out_n, 0);
    chk("R2", "bus_off kept", bus_off, 1);
  endtask

  task automatic t_drop_hold();
    @(negedge clk);
    hold = CW'(30); pg = 1'b1;
    wait_cyc(3 + PG_C + 15);
    chk("R6", "still in hold", rst_out_n, 0);
    drop_pg(3);
    run_seq(30, 8'h5A, 1'b0, "R6");
  endtask

  task automatic t_long_hold();
    drop_pg(3);
    chk("R5", "err clear before long hold", err, 0);
    run_seq(500, 8'hF0, 1'b1, "R5");
    drop_pg(4);
    chk("R5", "err sticky across pg loss", err, 1);
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R5", "err cleared by rst_ni", err, 0);
    wait_cyc(2);
    rst_n = 1;
    wait_cyc(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_drop_run();
    t_short_hold();
    t_glitch();
    t_drop_hold();
    t_long_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule